// File: doc/BRIEF.md
# Multicore Boot Release Table

This block is a small memory-mapped table that firmware uses to hold secondary processors at boot and to let them go. Each secondary core has one 32-byte slot. The slot holds a 64-bit start address, a 64-bit argument and a 32-bit processor identifier. An odd start address means the core keeps waiting. When any accepted write leaves a slot's start address even, the block fires a one-cycle release pulse for that core.

With the pulse, the block presents the start-up values: an in-window program counter, the argument, and a 64 MiB aligned mapping base. The mapping size is a constant output. The slot of the primary core and the slots of cores that are not implemented cannot be written.

The bus side is a single-cycle request port. Accesses are big-endian and can be byte, halfword or word wide. Read data comes back one cycle after the request.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, the slot of core i holds start address 1, argument i, processor identifier i and zero in every other byte, and no release pulse is active.
- R2: Slot bytes are big-endian: slot byte 0 is the most significant byte of the start address (bytes 0..7), and the argument occupies bytes 8..15 and the identifier bytes 20..23. The slot index is address bits [9:5]. A read of size 0 (byte), 1 (halfword) or 2 (word) returns the selected bytes right-aligned, with the offset bits below the access size ignored. The data is valid one cycle after the request.
- R3: Writes of size 0, 1 or 2 store the right-aligned write data into the addressed bytes in big-endian order. The same alignment rule as for reads applies.
- R4: Consider an accepted write that leaves bit 0 of the slot's 64-bit start address at 0. In the next cycle, exactly that core's bit of the release vector is high for one cycle. A write that leaves the address odd causes no release.
- R5: On release, the program counter equals the start address with all but its low 26 bits cleared. The mapping base equals the start address with its low 26 bits cleared. The window size output is always 0x4000000.
- R6: On release, the presented argument equals the slot's 64-bit argument as it is after the write.
- R7: On release, the slot's identifier field is replaced by the hardware identifier input of that core.
- R8: Every accepted write to a slot whose start address is even releases the core again, including a write that only changes the argument.
- R9: Writes to slot 0 are ignored: they cause no release and do not change the slot.
- R10: Slots at or above the implemented core count read as zero and ignore writes.
- R11: A read of size 3 returns zero with the error flag high. A write of size 3 changes nothing and causes no release.
- R12: A core's start-up outputs keep their values until that core's next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address in the table |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unsupported |
| req_wdata | input | 32 | Right-aligned write data |
| core_hwid | input | NUM_CORES*32 | Hardware identifier of each core |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Right-aligned read data |
| rd_err | output | 1 | Unsupported read size |
| rel_pulse | output | NUM_CORES | One-cycle release per core |
| boot_pc | output | NUM_CORES*64 | In-window program counter per core |
| boot_arg | output | NUM_CORES*64 | Argument per core |
| boot_map_base | output | NUM_CORES*64 | Aligned mapping base per core |
| boot_win_size | output | 64 | Mapping window size |

## Verification
The hardest case to reach is the split of the start address over two word writes. Firmware writes the upper word first, and the slot must stay held, because the lower word still carries the odd bit from reset. The release must then fire only on the second write. The bench drives exactly that order on one core. Later it rewrites only the argument of the same core to provoke a second release. It then checks that the program counter of that core survives releases of its neighbours.

// File: rtl/spin_rel_pkg.sv
package spin_rel_pkg;

    localparam int ENTRY_BYTES = 32;
    localparam int OFF_W       = $clog2(ENTRY_BYTES);
    localparam int OFF_START   = 0;
    localparam int OFF_ARG     = 8;
    localparam int OFF_PID     = 20;

    typedef logic [ENTRY_BYTES-1:0][7:0] entry_t;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_BAD  = 2'd3
    } acc_size_e;

    // big-endian 64-bit field starting at byte offset off
    function automatic logic [63:0] get_dword(entry_t e, int unsigned off);
        logic [63:0] v;
        v = '0;
        for (int k = 0; k < 8; k++) begin
            v = {v[55:0], e[OFF_W'(off + k)]};
        end
        return v;
    endfunction

    function automatic entry_t put_dword(entry_t e, int unsigned off, logic [63:0] v);
        entry_t r;
        r = e;
        for (int k = 0; k < 8; k++) begin
            r[OFF_W'(off + k)] = v[8*(7-k) +: 8];
        end
        return r;
    endfunction

    function automatic entry_t put_word(entry_t e, int unsigned off, logic [31:0] v);
        entry_t r;
        r = e;
        for (int k = 0; k < 4; k++) begin
            r[OFF_W'(off + k)] = v[8*(3-k) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/spin_decode.sv
module spin_decode
    import spin_rel_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off,
    output logic              size_ok
);

    assign idx = addr[ADDR_W-1:OFF_W];

    always_comb begin
        size_ok = 1'b1;
        case (acc_size_e'(size))
            ACC_BYTE: off = addr[OFF_W-1:0];
            ACC_HALF: off = {addr[OFF_W-1:1], 1'b0};
            ACC_WORD: off = {addr[OFF_W-1:2], 2'b00};
            default: begin
                off     = {addr[OFF_W-1:2], 2'b00};
                size_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/spin_wmerge.sv
module spin_wmerge
    import spin_rel_pkg::*;
(
    input  entry_t           cur,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    input  logic [31:0]      wdata,
    output entry_t           nxt
);

    always_comb begin
        nxt = cur;
        case (acc_size_e'(size))
            ACC_BYTE: nxt[off] = wdata[7:0];
            ACC_HALF: begin
                nxt[{off[OFF_W-1:1], 1'b0}] = wdata[15:8];
                nxt[{off[OFF_W-1:1], 1'b1}] = wdata[7:0];
            end
            ACC_WORD: begin
                for (int k = 0; k < 4; k++) begin
                    nxt[{off[OFF_W-1:2], 2'(k)}] = wdata[8*(3-k) +: 8];
                end
            end
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/spin_rlane.sv
module spin_rlane
    import spin_rel_pkg::*;
(
    input  entry_t           ent,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    output logic [31:0]      data
);

    always_comb begin
        data = '0;
        case (acc_size_e'(size))
            ACC_BYTE: data = {24'd0, ent[off]};
            ACC_HALF: data = {16'd0, ent[{off[OFF_W-1:1], 1'b0}], ent[{off[OFF_W-1:1], 1'b1}]};
            ACC_WORD: begin
                for (int k = 0; k < 4; k++) begin
                    data[8*(3-k) +: 8] = ent[{off[OFF_W-1:2], 2'(k)}];
                end
            end
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl
    import spin_rel_pkg::*;
#(
    parameter int MAX_CORES = 32,
    parameter int NUM_CORES = 4,
    parameter int WIN_BITS  = 26,
    localparam int ADDR_W   = $clog2(MAX_CORES * ENTRY_BYTES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [1:0]                     req_size,
    input  logic [31:0]                    req_wdata,
    input  logic [NUM_CORES-1:0][31:0]     core_hwid,
    output logic                           rd_valid,
    output logic [31:0]                    rd_data,
    output logic                           rd_err,
    output logic [NUM_CORES-1:0]           rel_pulse,
    output logic [NUM_CORES-1:0][63:0]     boot_pc,
    output logic [NUM_CORES-1:0][63:0]     boot_arg,
    output logic [NUM_CORES-1:0][63:0]     boot_map_base,
    output logic [63:0]                    boot_win_size
);

    localparam int IDX_W          = ADDR_W - OFF_W;
    localparam int CORE_W         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam logic [63:0] WIN_SIZE = 64'd1 << WIN_BITS;
    localparam logic [63:0] WIN_MASK = WIN_SIZE - 64'd1;

    typedef struct packed {
        entry_t [NUM_CORES-1:0]        ent;
        logic   [NUM_CORES-1:0]        rel;
        logic   [NUM_CORES-1:0][63:0]  pc;
        logic   [NUM_CORES-1:0][63:0]  arg;
        logic   [NUM_CORES-1:0][63:0]  base;
        logic                          rvalid;
        logic                          rerr;
        logic   [31:0]                 rdata;
    } state_t;

    function automatic state_t reset_state();
        state_t r;
        r = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            r.ent[i] = put_dword(r.ent[i], OFF_START, 64'd1);
            r.ent[i] = put_dword(r.ent[i], OFF_ARG, 64'(i));
            r.ent[i] = put_word(r.ent[i], OFF_PID, 32'(i));
        end
        return r;
    endfunction

    state_t s_d, s_q;

    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  off;
    logic              size_ok;
    logic              in_range;
    logic [CORE_W-1:0] cidx;
    entry_t            sel_ent;
    entry_t            merged;
    logic [31:0]       lane_data;
    logic [63:0]       new_start;
    logic              wr_accept;

    spin_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
        .addr    (req_addr),
        .size    (req_size),
        .idx     (idx),
        .off     (off),
        .size_ok (size_ok)
    );

    assign in_range = (32'(idx) < NUM_CORES);
    assign cidx     = CORE_W'(idx);
    assign sel_ent  = in_range ? s_q.ent[cidx] : '0;

    spin_wmerge wm_i (
        .cur   (sel_ent),
        .off   (off),
        .size  (req_size),
        .wdata (req_wdata),
        .nxt   (merged)
    );

    spin_rlane rl_i (
        .ent  (sel_ent),
        .off  (off),
        .size (req_size),
        .data (lane_data)
    );

    assign new_start = get_dword(merged, OFF_START);
    assign wr_accept = req_valid && req_write && size_ok && in_range && (idx != '0);

    always_comb begin
        s_d        = s_q;
        s_d.rel    = '0;
        s_d.rvalid = 1'b0;
        s_d.rerr   = 1'b0;

        if (req_valid && !req_write) begin
            s_d.rvalid = 1'b1;
            if (size_ok) begin
                s_d.rdata = lane_data;
            end else begin
                s_d.rdata = '0;
                s_d.rerr  = 1'b1;
            end
        end

        if (wr_accept) begin
            s_d.ent[cidx] = merged;
            if (!new_start[0]) begin
                s_d.rel[cidx]  = 1'b1;
                s_d.pc[cidx]   = new_start & WIN_MASK;
                s_d.base[cidx] = new_start & ~WIN_MASK;
                s_d.arg[cidx]  = get_dword(merged, OFF_ARG);
                s_d.ent[cidx]  = put_word(merged, OFF_PID, core_hwid[cidx]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= reset_state();
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid      = s_q.rvalid;
    assign rd_data       = s_q.rdata;
    assign rd_err        = s_q.rerr;
    assign rel_pulse     = s_q.rel;
    assign boot_pc       = s_q.pc;
    assign boot_arg      = s_q.arg;
    assign boot_map_base = s_q.base;
    assign boot_win_size = WIN_SIZE;

endmodule

// File: rtl/spin_rel_chk.sv
module spin_rel_chk #(
    parameter int NUM_CORES = 4,
    parameter int WIN_BITS  = 26
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_write,
    input logic                       rd_valid,
    input logic [31:0]                rd_data,
    input logic                       rd_err,
    input logic [NUM_CORES-1:0]       rel_pulse,
    input logic [NUM_CORES-1:0][63:0] boot_pc,
    input logic [NUM_CORES-1:0][63:0] boot_map_base
);

    // R4
    rel_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_pulse != '0) |-> $past(req_valid && req_write));

    // R4
    rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));

    // R2
    rd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // R11
    rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && rd_data == 32'd0));

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        // R5
        win_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rel_pulse[i] |-> ((boot_pc[i] >> WIN_BITS) == 64'd0 &&
                              boot_map_base[i][WIN_BITS-1:0] == '0));

        // R12
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rel_pulse[i] |-> ($stable(boot_pc[i]) && $stable(boot_map_base[i])));
    end

endmodule

bind spin_release_ctrl spin_rel_chk #(
    .NUM_CORES (NUM_CORES),
    .WIN_BITS  (WIN_BITS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .rd_err        (rd_err),
    .rel_pulse     (rel_pulse),
    .boot_pc       (boot_pc),
    .boot_map_base (boot_map_base)
);

// File: tb/spin_release_ctrl_tb.sv
module spin_release_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NC         = 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_write = 1'b0;
    logic [9:0]              req_addr = '0;
    logic [1:0]              req_size = '0;
    logic [31:0]             req_wdata = '0;
    logic [NC-1:0][31:0]     core_hwid;
    logic                    rd_valid;
    logic [31:0]             rd_data;
    logic                    rd_err;
    logic [NC-1:0]           rel_pulse;
    logic [NC-1:0][63:0]     boot_pc;
    logic [NC-1:0][63:0]     boot_arg;
    logic [NC-1:0][63:0]     boot_map_base;
    logic [63:0]             boot_win_size;

    int total = 0;
    int bad   = 0;
    logic [NC-1:0] last_rel;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NC; g++) begin : g_id
        assign core_hwid[g] = 32'hA0 + g;
    end

    spin_release_ctrl #(.MAX_CORES(32), .NUM_CORES(NC), .WIN_BITS(26)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .core_hwid     (core_hwid),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_err        (rd_err),
        .rel_pulse     (rel_pulse),
        .boot_pc       (boot_pc),
        .boot_arg      (boot_arg),
        .boot_map_base (boot_map_base),
        .boot_win_size (boot_win_size)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        last_rel = rel_pulse;
    endtask

    task automatic do_read(input logic [9:0] a, input logic [1:0] sz,
                           output logic [31:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data; e = rd_err;
        if (rd_valid !== 1'b1) begin
            total++; bad++;
            $display("FAIL R2 rd_valid actual=%b expected=1", rd_valid);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        chk("R1 no release after reset", 64'(rel_pulse), 64'd0);
        do_read(10'd32 + 10'd0, 2'd2, d, e); chk("R1 start hi core1", 64'(d), 64'd0);
        do_read(10'd32 + 10'd4, 2'd2, d, e); chk("R1 start lo core1", 64'(d), 64'd1);
        do_read(10'd32 + 10'd12, 2'd2, d, e); chk("R1 arg core1", 64'(d), 64'd1);
        do_read(10'd96 + 10'd20, 2'd2, d, e); chk("R1 pid core3", 64'(d), 64'd3);
        do_read(10'd32 + 10'd16, 2'd2, d, e); chk("R1 reserved core1", 64'(d), 64'd0);
    endtask

    task automatic t_read_layout();
        logic [31:0] d; logic e;
        do_read(10'd64 + 10'd7, 2'd0, d, e);  chk("R2 byte read", 64'(d), 64'h01);
        do_read(10'd64 + 10'd6, 2'd1, d, e);  chk("R2 half read", 64'(d), 64'h0001);
        do_read(10'd64 + 10'd23, 2'd0, d, e); chk("R2 pid byte", 64'(d), 64'h02);
        do_read(10'd64 + 10'd15, 2'd1, d, e); chk("R2 half align", 64'(d), 64'h0002);
        chk("R2 err low", 64'(e), 64'd0);
    endtask

    task automatic t_bad_size();
        logic [31:0] d; logic e;
        do_read(10'd36, 2'd3, d, e);
        chk("R11 bad read data", 64'(d), 64'd0);
        chk("R11 bad read err", 64'(e), 64'd1);
        do_write(10'd96 + 10'd4, 2'd3, 32'h0);
        chk("R11 bad write no release", 64'(last_rel), 64'd0);
        do_read(10'd96 + 10'd4, 2'd2, d, e);
        chk("R11 bad write no change", 64'(d), 64'd1);
    endtask

    task automatic t_two_word_release();
        logic [31:0] d; logic e;
        do_write(10'd32 + 10'd0, 2'd2, 32'h0000_0001);
        chk("R4 odd holds", 64'(last_rel), 64'd0);
        do_write(10'd32 + 10'd4, 2'd2, 32'h0C00_1234);
        chk("R4 release core1", 64'(last_rel), 64'b0010);
        chk("R5 pc", boot_pc[1], 64'h0000_0000_0000_1234);
        chk("R5 base", boot_map_base[1], 64'h0000_0001_0C00_0000);
        chk("R5 win size", boot_win_size, 64'h0000_0000_0400_0000);
        chk("R6 arg", boot_arg[1], 64'd1);
        @(negedge clk);
        chk("R4 pulse one cycle", 64'(rel_pulse), 64'd0);
        do_read(10'd32 + 10'd20, 2'd2, d, e);
        chk("R7 pid overwritten", 64'(d), 64'hA1);
        do_read(10'd32 + 10'd4, 2'd2, d, e);
        chk("R3 word stored", 64'(d), 64'h0C00_1234);
    endtask

    task automatic t_rerelease();
        do_write(10'd32 + 10'd12, 2'd2, 32'h0000_DEAD);
        chk("R8 re-release", 64'(last_rel), 64'b0010);
        chk("R8 new arg", boot_arg[1], 64'h0000_0000_0000_DEAD);
        chk("R8 pc kept", boot_pc[1], 64'h1234);
    endtask

    task automatic t_narrow_writes();
        do_write(10'd64 + 10'd7, 2'd0, 32'h0000_0040);
        chk("R3 byte write release", 64'(last_rel), 64'b0100);
        chk("R3 byte pc", boot_pc[2], 64'h40);
        chk("R5 byte base", boot_map_base[2], 64'h0);
        chk("R6 arg core2", boot_arg[2], 64'd2);
        chk("R12 core1 pc held", boot_pc[1], 64'h1234);
        do_write(10'd96 + 10'd6, 2'd1, 32'h0000_1000);
        chk("R3 half write release", 64'(last_rel), 64'b1000);
        chk("R3 half pc", boot_pc[3], 64'h1000);
        chk("R12 core2 pc held", boot_pc[2], 64'h40);
        chk("R12 core1 base held", boot_map_base[1], 64'h0000_0001_0C00_0000);
    endtask

    task automatic t_protected();
        logic [31:0] d; logic e;
        do_write(10'd4, 2'd2, 32'h0);
        chk("R9 slot0 no release", 64'(last_rel), 64'd0);
        do_read(10'd4, 2'd2, d, e);
        chk("R9 slot0 unchanged", 64'(d), 64'd1);
        do_write(10'd164, 2'd2, 32'h0);
        chk("R10 absent no release", 64'(last_rel), 64'd0);
        do_read(10'd164, 2'd2, d, e);
        chk("R10 absent reads zero", 64'(d), 64'd0);
        do_read(10'd180, 2'd2, d, e);
        chk("R10 absent pid zero", 64'(d), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_layout();
        t_bad_size();
        t_two_word_release();
        t_rerelease();
        t_narrow_writes();
        t_protected();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule